// File: doc/BRIEF.md
# Bridge Control Register File

This block holds the configuration and interrupt-control words of a system bridge. A master reaches it through a simple word-wide bus and issues only full 32-bit accesses. The address is a byte offset, and the word index is that offset shifted right by two. Twenty-eight words are defined. Most of them are plain storage, each with its own value after reset.

Two words differ from plain storage.

- **Interrupt enable.** This word cannot be written directly. It changes only through two companion words. One companion sets enable bits where the written value has ones. The other clears enable bits where the written value has ones.
- **Interrupt status.** This word is read-only. It shows an external status input.

One bit of the general-configuration word has a side effect. When a write takes that bit from 0 to 1, the block issues a one-cycle request for a system reset.

Read data is registered. It appears one clock after the read strobe and holds until the next read.

Top module: `ctlreg_bank`

## Requirements
- R1: After reset, each word reads its reset value, and all other words read zero. The non-zero reset values are:

  | Offset | Reset value |
  |--------|-------------|
  | 0x00 | 0x00000C40 |
  | 0x04 | 0x00001384 |
  | 0x08 | 0x2BFF8010 |
  | 0x0C | 0x255E0091 |
  | 0x10 | 0x00006140 |
  | 0x1C | 0x000001FF |
  | 0x20 | 0x000001FF |
  | 0x68 | 0x00000008 |
  | 0x6C | 0x10000000 |

  During reset, `sys_reset_req` and `rdata` are 0.
- R2: A write to a storage word stores all 32 bits. The storage words are every defined offset from 0x00 to 0x6C except 0x38 and 0x3C. Address bits [1:0] are ignored, and the word index is `addr[7:2]`.
- R3: A write to offset 0x30 stores the value in the 0x30 word. It also ORs the value into the interrupt enable, which is read at 0x38.
- R4: A write to offset 0x34 stores the value in the 0x34 word. It also clears each interrupt-enable bit where the value has a one.
- R5: Writes to 0x38 and 0x3C change nothing. A read of 0x38 returns the interrupt enable, which is zero after reset.
- R6: A read of 0x3C returns `irq_status_in` as sampled at the clock edge that takes the read.
- R7: Writes to offsets 0x70 and above change no word. Reads of those offsets return zero.
- R8: `sys_reset_req` is high for exactly the one cycle after the clock edge that takes a write to offset 0x04, and only when that write takes bit 2 of the 0x04 word from 0 to 1. The word still stores the written value. A write that leaves bit 2 at 1, or clears it, gives no pulse.
- R9: `rdata` changes only on the clock edge after `rd_en`. It then holds while `rd_en` is low. When a read and a write hit the same word in one cycle, the read returns the value from before the write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe for the current cycle |
| rd_en | input | 1 | Read strobe for the current cycle |
| addr | input | ADDR_W | Byte offset of the access |
| wdata | input | 32 | Write data |
| irq_status_in | input | 32 | External interrupt status shown at 0x3C |
| rdata | output | 32 | Registered read data |
| sys_reset_req | output | 1 | One-cycle system reset request |

## Verification
The reset request is the hardest situation to reach from the ports. Bit 2 of the configuration word is already 1 after reset, so a write that sets it does nothing until an earlier write has cleared the bit. The stimulus therefore runs a directed sequence of clear, set, and repeated set on offset 0x04, and checks that exactly one pulse appears. Random writes to 0x04 are mixed in later, and a bench model predicts each pulse from the bit value it has stored.

// File: rtl/ctlreg_pkg.sv
package ctlreg_pkg;
   localparam int unsigned IDX_GEN  = 1;
   localparam int unsigned IDX_SET  = 12;
   localparam int unsigned IDX_CLR  = 13;
   localparam int unsigned IDX_EN   = 14;
   localparam int unsigned IDX_STAT = 15;

   function automatic logic [31:0] reset_value(input int unsigned idx);
      case (idx)
         0:       return 32'h0000_0C40;
         1:       return 32'h0000_1384;
         2:       return 32'h2BFF_8010;
         3:       return 32'h255E_0091;
         4:       return 32'h0000_6140;
         7:       return 32'h0000_01FF;
         8:       return 32'h0000_01FF;
         26:      return 32'h0000_0008;
         27:      return 32'h1000_0000;
         default: return 32'h0;
      endcase
   endfunction
endpackage

// File: rtl/ctlreg_decode.sv
module ctlreg_decode #(
   parameter int unsigned ADDR_W   = 8,
   parameter int unsigned NUM_REGS = 28,
   localparam int unsigned IDX_W   = ADDR_W - 2
) (
   input  logic                wr_en,
   input  logic [ADDR_W-1:0]   addr,
   output logic [IDX_W-1:0]    idx,
   output logic                hit,
   output logic [NUM_REGS-1:0] wr_sel
);
   localparam logic [IDX_W:0] LIMIT = (IDX_W+1)'(NUM_REGS);

   assign idx = addr[ADDR_W-1:2];
   assign hit = ({1'b0, idx} < LIMIT);

   for (genvar i = 0; i < NUM_REGS; i++) begin : g_sel
      assign wr_sel[i] = wr_en && (idx == IDX_W'(i));
   end
endmodule

// File: rtl/ctlreg_array.sv
module ctlreg_array
   import ctlreg_pkg::*;
#(
   parameter int unsigned NUM_REGS = 28,
   parameter int unsigned DATA_W   = 32
) (
   input  logic                             clk,
   input  logic                             rst_n,
   input  logic [NUM_REGS-1:0]              wr_sel,
   input  logic [DATA_W-1:0]                wdata,
   output logic [NUM_REGS-1:0][DATA_W-1:0]  regs_q
);
   for (genvar i = 0; i < NUM_REGS; i++) begin : g_word
      logic [DATA_W-1:0] q;
      if (i == IDX_EN) begin : g_enable
         always_ff @(posedge clk) begin
            if (!rst_n)                 q <= '0;
            else if (wr_sel[IDX_SET])   q <= q | wdata;
            else if (wr_sel[IDX_CLR])   q <= q & ~wdata;
         end
         assert_set_ors_R3: assert property (@(posedge clk) disable iff (!rst_n)
            wr_sel[IDX_SET] |=> ((q & $past(wdata)) == $past(wdata)));
         assert_clr_clears_R4: assert property (@(posedge clk) disable iff (!rst_n)
            wr_sel[IDX_CLR] |=> ((q & $past(wdata)) == '0));
         assert_en_readonly_R5: assert property (@(posedge clk) disable iff (!rst_n)
            !(wr_sel[IDX_SET] || wr_sel[IDX_CLR]) |=> $stable(q));
      end else if (i == IDX_STAT) begin : g_status
         assign q = '0;
      end else begin : g_plain
         always_ff @(posedge clk) begin
            if (!rst_n)         q <= DATA_W'(reset_value(i));
            else if (wr_sel[i]) q <= wdata;
         end
         assert_plain_store_R2: assert property (@(posedge clk) disable iff (!rst_n)
            wr_sel[i] |=> (q == $past(wdata)));
      end
      assign regs_q[i] = q;
   end
endmodule

// File: rtl/ctlreg_rstreq.sv
module ctlreg_rstreq #(
   parameter int unsigned RST_BIT = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic gen_wr,
   input  logic cur_bit,
   input  logic new_bit,
   output logic pulse
);
   always_ff @(posedge clk) begin
      if (!rst_n) pulse <= 1'b0;
      else        pulse <= gen_wr && !cur_bit && new_bit;
   end

   assert_single_cycle_R8: assert property (@(posedge clk) disable iff (!rst_n)
      pulse |=> !pulse);
   assert_bit_now_set_R8: assert property (@(posedge clk) disable iff (!rst_n)
      pulse |-> cur_bit);
endmodule

// File: rtl/ctlreg_rdport.sv
module ctlreg_rdport
   import ctlreg_pkg::*;
#(
   parameter int unsigned NUM_REGS = 28,
   parameter int unsigned DATA_W   = 32,
   parameter int unsigned IDX_W    = 6
) (
   input  logic                            clk,
   input  logic                            rst_n,
   input  logic                            rd_en,
   input  logic [IDX_W-1:0]                idx,
   input  logic                            hit,
   input  logic [NUM_REGS-1:0][DATA_W-1:0] regs_q,
   input  logic [DATA_W-1:0]               status_in,
   output logic [DATA_W-1:0]               rdata
);
   logic [DATA_W-1:0] sel;

   always_comb begin
      sel = '0;
      for (int i = 0; i < NUM_REGS; i++) begin
         if (idx == IDX_W'(i)) sel = (i == IDX_STAT) ? status_in : regs_q[i];
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n)     rdata <= '0;
      else if (rd_en) rdata <= hit ? sel : '0;
   end

   assert_undef_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en && !hit) |=> (rdata == '0));
   assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_en |=> $stable(rdata));
   assert_status_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en && idx == IDX_W'(IDX_STAT)) |=> (rdata == $past(status_in)));
endmodule

// File: rtl/ctlreg_bank.sv
module ctlreg_bank
   import ctlreg_pkg::*;
#(
   parameter int unsigned ADDR_W   = 8,
   parameter int unsigned NUM_REGS = 28,
   parameter int unsigned DATA_W   = 32,
   parameter int unsigned RST_BIT  = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic              rd_en,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] wdata,
   input  logic [DATA_W-1:0] irq_status_in,
   output logic [DATA_W-1:0] rdata,
   output logic              sys_reset_req
);
   localparam int unsigned IDX_W = ADDR_W - 2;

   initial begin
      assert (DATA_W == 32) else $error("ctlreg_bank: DATA_W must be 32");
      assert (NUM_REGS > IDX_STAT && NUM_REGS <= (1 << IDX_W))
         else $error("ctlreg_bank: NUM_REGS out of range");
      assert (RST_BIT < DATA_W) else $error("ctlreg_bank: RST_BIT out of range");
   end

   logic [IDX_W-1:0]                idx;
   logic                            hit;
   logic [NUM_REGS-1:0]             wr_sel;
   logic [NUM_REGS-1:0][DATA_W-1:0] regs_q;

   ctlreg_decode #(.ADDR_W(ADDR_W), .NUM_REGS(NUM_REGS)) u_decode (
      .wr_en(wr_en), .addr(addr), .idx(idx), .hit(hit), .wr_sel(wr_sel));

   ctlreg_array #(.NUM_REGS(NUM_REGS), .DATA_W(DATA_W)) u_array (
      .clk(clk), .rst_n(rst_n), .wr_sel(wr_sel), .wdata(wdata), .regs_q(regs_q));

   ctlreg_rstreq #(.RST_BIT(RST_BIT)) u_rstreq (
      .clk(clk), .rst_n(rst_n), .gen_wr(wr_sel[IDX_GEN]),
      .cur_bit(regs_q[IDX_GEN][RST_BIT]), .new_bit(wdata[RST_BIT]),
      .pulse(sys_reset_req));

   ctlreg_rdport #(.NUM_REGS(NUM_REGS), .DATA_W(DATA_W), .IDX_W(IDX_W)) u_rdport (
      .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .idx(idx), .hit(hit),
      .regs_q(regs_q), .status_in(irq_status_in), .rdata(rdata));

   assert_undef_nowrite_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && !hit) |=> $stable(regs_q));
endmodule

// File: tb/test_ctlreg_bank.sv
module test_ctlreg_bank;
   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic        rd_en = 1'b0;
   logic [7:0]  addr = '0;
   logic [31:0] wdata = '0;
   logic [31:0] irq_status_in = '0;
   logic [31:0] rdata;
   logic        sys_reset_req;

   int vectors = 0;
   int fails = 0;
   bit done = 0;

   logic [31:0] m_regs [28];
   logic [31:0] m_en;

   always #(CLK_PERIOD/2) clk = ~clk;

   ctlreg_bank i_ctlreg_bank (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
      .wdata(wdata), .irq_status_in(irq_status_in), .rdata(rdata),
      .sys_reset_req(sys_reset_req));

   function automatic logic [31:0] rv(int i);
      case (i)
         0: return 32'hC40;       1: return 32'h1384;
         2: return 32'h2BFF8010;  3: return 32'h255E0091;
         4: return 32'h6140;      7: return 32'h1FF;
         8: return 32'h1FF;       26: return 32'h8;
         27: return 32'h10000000;
         default: return 32'h0;
      endcase
   endfunction

   function automatic logic [31:0] exp_read(logic [7:0] a);
      int i = int'(a[7:2]);
      if (i >= 28) return 32'h0;
      if (i == 14) return m_en;
      if (i == 15) return irq_status_in;
      return m_regs[i];
   endfunction

   task automatic check(string req, logic [31:0] act, logic [31:0] exp);
      vectors++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   // returns expected pulse, updates model
   function automatic logic model_write(logic [7:0] a, logic [31:0] v);
      int i = int'(a[7:2]);
      logic p = 1'b0;
      if (i >= 28 || i == 14 || i == 15) return 1'b0;
      if (i == 1) p = !m_regs[1][2] && v[2];
      m_regs[i] = v;
      if (i == 12) m_en = m_en | v;
      if (i == 13) m_en = m_en & ~v;
      return p;
   endfunction

   task automatic do_wr(logic [7:0] a, logic [31:0] v, string req);
      logic p;
      @(negedge clk);
      wr_en = 1'b1; addr = a; wdata = v;
      p = model_write(a, v);
      @(posedge clk);
      @(negedge clk);
      wr_en = 1'b0;
      check({req, " pulse"}, {31'b0, sys_reset_req}, {31'b0, p});
   endtask

   task automatic do_rd(logic [7:0] a, string req);
      logic [31:0] e;
      @(negedge clk);
      rd_en = 1'b1; addr = a;
      e = exp_read(a);
      @(posedge clk);
      @(negedge clk);
      rd_en = 1'b0;
      check(req, rdata, e);
   endtask

   task automatic do_rdwr(logic [7:0] a, logic [31:0] v);
      logic [31:0] e;
      logic p;
      @(negedge clk);
      rd_en = 1'b1; wr_en = 1'b1; addr = a; wdata = v;
      e = exp_read(a);
      p = model_write(a, v);
      @(posedge clk);
      @(negedge clk);
      rd_en = 1'b0; wr_en = 1'b0;
      check("R9 read-before-write", rdata, e);
      check("R8 pulse on rdwr", {31'b0, sys_reset_req}, {31'b0, p});
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         fails++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
         $finish;
      end
   end

   initial begin
      logic [31:0] held;
      void'($urandom(32'd20240607));
      for (int i = 0; i < 28; i++) m_regs[i] = rv(i);
      m_en = '0;
      repeat (3) @(posedge clk);
      @(negedge clk);
      check("R1 rdata in reset", rdata, 32'h0);
      check("R1 pulse in reset", {31'b0, sys_reset_req}, 32'h0);
      rst_n = 1'b1;

      // R1: reset values of every word
      for (int i = 0; i < 28; i++) do_rd(8'(i * 4), "R1 reset value");

      // R2: storage words, ignored low address bits
      do_wr(8'h23, 32'hDEADBEEF, "R2");
      do_rd(8'h20, "R2 store with low bits");
      do_wr(8'h6C, 32'h0F0F0F0F, "R2");
      do_rd(8'h6E, "R2 store last word");

      // R3/R4: set and clear companions
      do_wr(8'h30, 32'h0000_00F3, "R3");
      do_rd(8'h38, "R3 enable after set");
      do_rd(8'h30, "R3 set word stored");
      do_wr(8'h30, 32'h8000_0100, "R3");
      do_rd(8'h38, "R3 enable accumulates");
      do_wr(8'h34, 32'h8000_0011, "R4");
      do_rd(8'h38, "R4 enable after clear");
      do_rd(8'h34, "R4 clear word stored");

      // R5: read-only words
      do_wr(8'h38, 32'hFFFF_FFFF, "R5");
      do_rd(8'h38, "R5 enable write ignored");
      do_wr(8'h3C, 32'h1234_5678, "R5");
      irq_status_in = 32'hA5A5_0001;
      do_rd(8'h3C, "R6 status read");
      irq_status_in = 32'h0000_8000;
      do_rd(8'h3D, "R6 status follows input");

      // R7: undefined offsets
      do_wr(8'h70, 32'hFFFF_FFFF, "R7");
      do_rd(8'h70, "R7 undefined read zero");
      do_rd(8'hFC, "R7 top undefined read zero");
      for (int i = 0; i < 28; i++) do_rd(8'(i * 4), "R7 no side effect");

      // R8: reset request edge
      do_wr(8'h04, 32'h0000_1384, "R8 keep bit high");
      do_wr(8'h04, 32'h0000_1380, "R8 clear bit");
      do_wr(8'h04, 32'h0000_1384, "R8 rising bit");
      do_wr(8'h04, 32'h0000_1384, "R8 repeat set");
      do_rd(8'h04, "R8 config stored");

      // R9: hold and read-before-write
      do_rd(8'h08, "R9 read");
      held = rdata;
      do_wr(8'h08, 32'h5555_AAAA, "R9");
      check("R9 rdata holds", rdata, held);
      do_rdwr(8'h08, 32'h1111_2222);
      do_rd(8'h08, "R9 new value");

      // random mix
      for (int n = 0; n < 600; n++) begin
         logic [7:0] a = 8'($urandom_range(0, 31) * 4) | 8'($urandom_range(0, 3));
         logic [31:0] v = $urandom();
         int k = $urandom_range(0, 9);
         if ($urandom_range(0, 7) == 0) a = 8'h04 | 8'($urandom_range(0, 3));
         if ($urandom_range(0, 15) == 0) a = 8'($urandom_range(28, 63) * 4);
         irq_status_in = $urandom();
         if (k < 4)      do_wr(a, v, "R2 random");
         else if (k < 9) do_rd(a, "R2 random read");
         else            do_rdwr(a, v);
      end

      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
   end
endmodule